// File: doc/BRIEF.md
# DMA Transfer Timing Sequencer

This block models how long a small DMA channel engine holds the bus for each transfer. A transfer request arrives with a set of configuration bits. The sequencer works out from those bits and from its transfer counter the exact number of bus clocks the transfer occupies. It holds `busy_o` for that many clocks and pulses `done_o` in the last one. It then updates the counter, and when the counter has run out it strobes an end-of-transfer interrupt a fixed number of clocks later. No data is moved. Addresses, arithmetic and wait states are not modelled. The block only produces the timing envelope that a bus model or a performance model lays around such an engine.

Software loads the transfer counter while the channel is idle. A request is started when the channel is idle, the counter is non-zero and no higher-priority interrupt sequence is running. If it cannot start at once, one request is parked together with its configuration and started as soon as the way is clear.

Top module: `dma_timing_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `busy_o`, `done_o` and `eot_irq_o` at 0 and `cnt_o` at 0, and any parked request is forgotten.
- R2: With the channel idle, `cnt_load_i` high for one cycle makes `cnt_o` equal `cnt_val_i` in the following cycle.
- R3: A request that is accepted at a clock edge makes `busy_o` high from the next cycle for exactly T consecutive cycles. `done_o` is high only in the last of those cycles, and `busy_o` is low in the cycle after.
- R4: With the multiple mode off, T = 6 + (26 + a + b + c + d)·m + (4 + e)·n. Here a = -1 for a memory source (`src_mem_i`=1) and 0 for an immediate source. b = 1 for a fixed source (`src_inc_i`=0) and 0 for an incrementing one. c is the same for the destination (`dst_inc_i`). n = 1 when the counter at start is 2 or more, and 0 when it is 1. For example, a memory source with an incrementing source and a fixed destination takes 36 clocks at count 2 and 32 clocks at count 1.
- R5: The calculation term d is 0 with `calc_en_i`=0. With `calc_en_i`=1 it is 8 for an incrementing source and 7 otherwise.
- R6: The chain term e is 4 with `chain_en_i`=1 and 0 otherwise.
- R7: In burst mode (`burst_en_i`=1, multiple mode off), m equals the counter value at start and the counter becomes 0 at completion. Otherwise m = 1.
- R8: In multiple mode (`multi_en_i`=1), T = 21 + (11 + b + c)·k, where k is the 3-bit `multi_num_i` (0 to 7). The burst bit is ignored.
- R9: Outside burst mode, the counter drops by exactly one at completion. The new value is visible in the cycle after the `done_o` cycle.
- R10: When a completion leaves the counter at 0, `eot_irq_o` is high for one cycle, 8 cycles after the `done_o` cycle. Completions that leave the counter non-zero produce no strobe.
- R11: No transfer starts while `prio_irq_busy_i` is high. A request waiting on it starts at the first edge where that input is low, so `busy_o` rises one cycle later.
- R12: A request that cannot start at once is parked with the configuration present in its request cycle. It starts at the edge after the cycle in which `busy_o` first reads low. A further request while one is parked is discarded.
- R13: A request made while the counter is 0 is discarded. A parked request is also discarded once the channel is idle with the counter at 0.
- R14: Changes on the configuration inputs and on `cnt_load_i`/`cnt_val_i` while `busy_o` is high affect neither the duration nor the count of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Transfer request, sampled each cycle |
| prio_irq_busy_i | input | 1 | A higher-priority interrupt sequence is running |
| src_mem_i | input | 1 | 1: source is in memory; 0: immediate source |
| src_inc_i | input | 1 | 1: source address increments; 0: fixed |
| dst_inc_i | input | 1 | 1: destination address increments; 0: fixed |
| calc_en_i | input | 1 | Calculation function enabled |
| chain_en_i | input | 1 | Chain transfer enabled |
| burst_en_i | input | 1 | Burst mode: the whole count in one transfer |
| multi_en_i | input | 1 | Multiple-transfer mode |
| multi_num_i | input | 3 | Number of transfers in multiple mode (k) |
| cnt_load_i | input | 1 | Load the transfer counter (idle only) |
| cnt_val_i | input | CW | Value to load into the counter |
| busy_o | output | 1 | Channel occupies the bus |
| done_o | output | 1 | One-cycle pulse in the last busy cycle |
| cnt_o | output | CW | Current transfer counter |
| eot_irq_o | output | 1 | One-cycle end-of-transfer interrupt strobe |

## Verification
The bench targets the edges of the duration formula:
- count 1 against count 2, where n flips;
- a burst at count 1;
- multiple mode with k = 0 and k = 7;
- the calculation term with both source update settings.

A design that mixed up n or d would be one or a few clocks off, and the busy-length check catches that.

It also targets the order of events around completion:
- a request parked during a busy transfer, which must start after exactly one idle cycle with the configuration it carried;
- a second parked request, which must vanish;
- a request at count 0, which must not start;
- configuration and count loads toggled during busy, which must leave the running transfer alone.

A design that latched the configuration at start instead of at request time would give the wrong length for the parked transfer. The interrupt is checked to land on exactly the eighth cycle after `done_o`, so an off-by-one delay shows up as the strobe arriving in the wrong slot.

// File: rtl/dma_timing_pkg.sv
// Package: shared types for the DMA transfer timing sequencer.
// Assumes: the multiple-transfer number is a 3-bit field.
package dma_timing_pkg;

    localparam int MULTI_W = 3;

    // Configuration captured with a request
    typedef struct packed {
        logic               src_mem;
        logic               src_inc;
        logic               dst_inc;
        logic               calc_en;
        logic               chain_en;
        logic               burst_en;
        logic               multi_en;
        logic [MULTI_W-1:0] multi_num;
    } xfer_cfg_t;

endpackage

// File: rtl/dma_xfer_cost.sv
// Module: dma_xfer_cost
// Computes how many bus clocks a transfer occupies from its configuration
// and the counter value at start. Purely combinational.
// Assumes: cnt_i is non-zero when the result is used; DW holds the largest
// burst duration (35 * (2**CW - 1) + 14).
module dma_xfer_cost
    import dma_timing_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = CW + 8
) (
    input  xfer_cfg_t       cfg_i,
    input  logic [CW-1:0]   cnt_i,
    output logic [DW-1:0]   dur_o
);

    logic [DW-1:0] per_beat;
    logic [DW-1:0] beats;
    logic [DW-1:0] tail;
    logic [DW-1:0] multi_step;
    logic [DW-1:0] multi_dur;
    logic [DW-1:0] plain_dur;

    // Per-beat cost, beat count and closing cost of a normal transfer
    always_comb begin
        per_beat = DW'(25);
        if (!cfg_i.src_mem) per_beat = per_beat + DW'(1);
        if (!cfg_i.src_inc) per_beat = per_beat + DW'(1);
        if (!cfg_i.dst_inc) per_beat = per_beat + DW'(1);
        if (cfg_i.calc_en)  per_beat = per_beat + (cfg_i.src_inc ? DW'(8) : DW'(7));
        beats = cfg_i.burst_en ? DW'(cnt_i) : DW'(1);
        tail  = DW'(0);
        if (cnt_i > CW'(1)) tail = cfg_i.chain_en ? DW'(8) : DW'(4);
        plain_dur = DW'(6) + per_beat * beats + tail;
    end

    // Duration in multiple-transfer mode
    always_comb begin
        multi_step = DW'(11);
        if (!cfg_i.src_inc) multi_step = multi_step + DW'(1);
        if (!cfg_i.dst_inc) multi_step = multi_step + DW'(1);
        multi_dur = DW'(21) + multi_step * DW'(cfg_i.multi_num);
    end

    assign dur_o = cfg_i.multi_en ? multi_dur : plain_dur;

endmodule

// File: rtl/dma_req_slot.sv
// Module: dma_req_slot
// Holds one parked request with the configuration seen in its request cycle.
// Assumes: capture_i and clear_i are never high together (the owner
// guarantees this); clear_i wins if they are.
module dma_req_slot
    import dma_timing_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      capture_i,
    input  logic      clear_i,
    input  xfer_cfg_t cfg_i,
    output logic      pend_o,
    output xfer_cfg_t cfg_o
);

    // Park or release the waiting request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            cfg_o  <= '0;
        end else if (clear_i) begin
            pend_o <= 1'b0;
        end else if (capture_i) begin
            pend_o <= 1'b1;
            cfg_o  <= cfg_i;
        end
    end

endmodule

// File: rtl/dma_eot_timer.sv
// Module: dma_eot_timer
// Emits a one-cycle strobe DELAY cycles after the cycle in which fire_i is high.
// Assumes: DELAY >= 1; a new fire_i restarts the countdown.
module dma_eot_timer #(
    parameter int DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic irq_o
);

    localparam int TW = (DELAY > 1) ? $clog2(DELAY) : 1;

    logic          armed;
    logic [TW-1:0] tmr;

    // Count down from the completion to the strobe slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            tmr   <= '0;
        end else if (fire_i) begin
            armed <= 1'b1;
            tmr   <= TW'(DELAY - 1);
        end else if (armed) begin
            if (tmr == '0) armed <= 1'b0;
            else           tmr   <= tmr - TW'(1);
        end
    end

    assign irq_o = armed && (tmr == '0);

endmodule

// File: rtl/dma_timing_seq.sv
// Module: dma_timing_seq (top)
// Timing model of a DMA channel: accepts requests, holds busy for a
// configuration-dependent number of bus clocks, updates the transfer counter
// and strobes an end-of-transfer interrupt IRQ_DELAY cycles after completion.
// Assumes: the counter is loaded only while idle; one request may wait.
module dma_timing_seq
    import dma_timing_pkg::*;
#(
    parameter int CW        = 8,
    parameter int IRQ_DELAY = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               prio_irq_busy_i,
    input  logic               src_mem_i,
    input  logic               src_inc_i,
    input  logic               dst_inc_i,
    input  logic               calc_en_i,
    input  logic               chain_en_i,
    input  logic               burst_en_i,
    input  logic               multi_en_i,
    input  logic [MULTI_W-1:0] multi_num_i,
    input  logic               cnt_load_i,
    input  logic [CW-1:0]      cnt_val_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [CW-1:0]      cnt_o,
    output logic               eot_irq_o
);

    localparam int DW = CW + 8;

    xfer_cfg_t     in_cfg;
    xfer_cfg_t     pend_cfg;
    xfer_cfg_t     sel_cfg;
    logic          pend;
    logic          busy;
    logic          run_to_zero;
    logic          start;
    logic          capture;
    logic          drop;
    logic          last;
    logic          fire;
    logic          cnt_nz;
    logic [CW-1:0] cnt;
    logic [CW-1:0] next_cnt;
    logic [DW-1:0] rem;
    logic [DW-1:0] dur;

    assign in_cfg = '{
        src_mem:   src_mem_i,
        src_inc:   src_inc_i,
        dst_inc:   dst_inc_i,
        calc_en:   calc_en_i,
        chain_en:  chain_en_i,
        burst_en:  burst_en_i,
        multi_en:  multi_en_i,
        multi_num: multi_num_i
    };

    // Choose the configuration of the request about to start
    assign sel_cfg = pend ? pend_cfg : in_cfg;

    // Start, park and discard decisions for the cycle
    always_comb begin
        cnt_nz  = (cnt != '0);
        start   = !busy && !prio_irq_busy_i && !cnt_load_i && cnt_nz && (pend || req_i);
        capture = req_i && !pend && !start && cnt_nz;
        drop    = !busy && !cnt_nz;
        last    = busy && (rem == '0);
    end

    // Counter value after the running transfer completes
    always_comb begin
        next_cnt = run_to_zero ? '0 : cnt - CW'(1);
        fire     = last && (next_cnt == '0);
    end

    dma_req_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .clear_i   (start || drop),
        .cfg_i     (in_cfg),
        .pend_o    (pend),
        .cfg_o     (pend_cfg)
    );

    dma_xfer_cost #(
        .CW (CW),
        .DW (DW)
    ) u_cost (
        .cfg_i (sel_cfg),
        .cnt_i (cnt),
        .dur_o (dur)
    );

    dma_eot_timer #(
        .DELAY (IRQ_DELAY)
    ) u_eot (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .irq_o  (eot_irq_o)
    );

    // Busy window: load the remaining-cycle count at start, run it down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            rem         <= '0;
            run_to_zero <= 1'b0;
        end else if (start) begin
            busy        <= 1'b1;
            rem         <= dur - DW'(1);
            run_to_zero <= sel_cfg.burst_en && !sel_cfg.multi_en;
        end else if (busy) begin
            if (rem == '0) busy <= 1'b0;
            else           rem  <= rem - DW'(1);
        end
    end

    // Transfer counter: update on completion, load only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= next_cnt;
        end else if (cnt_load_i && !busy) begin
            cnt <= cnt_val_i;
        end
    end

    assign busy_o = busy;
    assign done_o = last;
    assign cnt_o  = cnt;

endmodule

// File: rtl/dma_timing_seq_chk.sv
// Module: dma_timing_seq_chk
// Property checker for dma_timing_seq, attached to every instance by bind.
// Assumes: observes the top-level ports only.
module dma_timing_seq_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prio_irq_busy_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [CW-1:0] cnt_o,
    input logic          eot_irq_o
);

    // R1: a reset edge leaves every output cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !eot_irq_o && cnt_o == '0));

    // R3: the done pulse only appears inside a busy window
    a_r3_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R3: busy drops right after done
    a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R3: busy never ends without a done pulse
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R14: counter untouched in the middle of a transfer
    a_r14_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(cnt_o));

    // R11: no start while the higher-priority sequence runs
    a_r11_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(prio_irq_busy_i));

    // R13: no start from an empty counter
    a_r13_start_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(cnt_o) != '0));

    // R10: the interrupt strobe lasts one cycle
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        eot_irq_o |=> !eot_irq_o);

endmodule

bind dma_timing_seq dma_timing_seq_chk #(
    .CW (CW)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .prio_irq_busy_i (prio_irq_busy_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .cnt_o           (cnt_o),
    .eot_irq_o       (eot_irq_o)
);

// File: tb/dma_timing_seq_bench.sv
`timescale 1ns/1ps
// Bench for dma_timing_seq: directed corner cases plus seeded random transfers,
// with expected durations, counts and strobe slots computed by bench functions.
module dma_timing_seq_bench;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          prio_irq_busy_i = 1'b0;
    logic          src_mem_i = 1'b0;
    logic          src_inc_i = 1'b0;
    logic          dst_inc_i = 1'b0;
    logic          calc_en_i = 1'b0;
    logic          chain_en_i = 1'b0;
    logic          burst_en_i = 1'b0;
    logic          multi_en_i = 1'b0;
    logic [2:0]    multi_num_i = 3'd0;
    logic          cnt_load_i = 1'b0;
    logic [CW-1:0] cnt_val_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [CW-1:0] cnt_o;
    logic          eot_irq_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc_total = 0;

    // bench model of the configuration and counter
    bit m_sm, m_si, m_di, m_calc, m_chain, m_burst, m_multi;
    int m_k;
    int mcnt;

    dma_timing_seq #(.CW(CW), .IRQ_DELAY(8)) u_dma_timing_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req_i),
        .prio_irq_busy_i (prio_irq_busy_i),
        .src_mem_i       (src_mem_i),
        .src_inc_i       (src_inc_i),
        .dst_inc_i       (dst_inc_i),
        .calc_en_i       (calc_en_i),
        .chain_en_i      (chain_en_i),
        .burst_en_i      (burst_en_i),
        .multi_en_i      (multi_en_i),
        .multi_num_i     (multi_num_i),
        .cnt_load_i      (cnt_load_i),
        .cnt_val_i       (cnt_val_i),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .cnt_o           (cnt_o),
        .eot_irq_o       (eot_irq_o)
    );

    always #2 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL R3 watchdog: cycles %0d expected below %0d", cyc_total, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // duration from the requirement formulas
    function automatic int exp_time();
        int a, b, c, d, e, m, n;
        b = m_si ? 0 : 1;
        c = m_di ? 0 : 1;
        if (m_multi) return 21 + (11 + b + c) * m_k;
        a = m_sm ? -1 : 0;
        d = !m_calc ? 0 : (m_si ? 8 : 7);
        e = m_chain ? 4 : 0;
        m = m_burst ? mcnt : 1;
        n = (mcnt >= 2) ? 1 : 0;
        return 6 + (26 + a + b + c + d) * m + (4 + e) * n;
    endfunction

    function automatic int exp_after();
        if (!m_multi && m_burst) return 0;
        return mcnt - 1;
    endfunction

    task automatic set_cfg(bit sm, bit si, bit di, bit calc, bit chain, bit burst, bit multi, int k);
        m_sm = sm; m_si = si; m_di = di; m_calc = calc; m_chain = chain;
        m_burst = burst; m_multi = multi; m_k = k;
        src_mem_i = sm; src_inc_i = si; dst_inc_i = di; calc_en_i = calc;
        chain_en_i = chain; burst_en_i = burst; multi_en_i = multi;
        multi_num_i = 3'(k);
    endtask

    task automatic scramble_cfg();
        src_mem_i = 1'($urandom); src_inc_i = 1'($urandom); dst_inc_i = 1'($urandom);
        calc_en_i = 1'($urandom); chain_en_i = 1'($urandom); burst_en_i = 1'($urandom);
        multi_en_i = 1'($urandom); multi_num_i = 3'($urandom);
    endtask

    task automatic scramble_all();
        scramble_cfg();
        cnt_load_i = 1'($urandom);
        cnt_val_i = CW'($urandom);
    endtask

    task automatic load(int v);
        cnt_load_i = 1'b1;
        cnt_val_i = CW'(v);
        @(negedge clk);
        cnt_load_i = 1'b0;
        chk(int'(cnt_o) == v, "R2", int'(cnt_o), v);
        mcnt = v;
    endtask

    // request, optionally held off by the priority input
    task automatic launch(int hold);
        req_i = 1'b1;
        prio_irq_busy_i = (hold > 0);
        @(negedge clk);
        req_i = 1'b0;
        for (int h = 0; h < hold; h++) begin
            chk(busy_o === 1'b0, "R11", int'(busy_o), 0);
            scramble_cfg();
            if (h == hold - 1) prio_irq_busy_i = 1'b0;
            @(negedge clk);
        end
        chk(busy_o === 1'b1, "R3", int'(busy_o), 1);
    endtask

    // measure the busy window from the current negedge, then the strobe slot
    task automatic observe(int exp_t, int exp_cnt, bit exp_irq, bit chk_irq, bit mess,
                           string tag, string ctag);
        int cyc, dn, dat, seen;
        bit ok;
        cyc = 0; dn = 0; dat = 0; seen = 0; ok = 1;
        while (busy_o === 1'b1 && cyc < 4000) begin
            cyc++;
            if (done_o === 1'b1) begin
                dn++;
                dat = cyc;
            end
            if (mess) scramble_all();
            @(negedge clk);
        end
        cnt_load_i = 1'b0;
        chk(cyc == exp_t, tag, cyc, exp_t);
        chk(dn == 1 && dat == exp_t, "R3", dat, exp_t);
        chk(int'(cnt_o) == exp_cnt, ctag, int'(cnt_o), exp_cnt);
        if (chk_irq) begin
            for (int k = 1; k <= 10; k++) begin
                if (eot_irq_o === 1'b1) begin
                    if (seen == 0) seen = k;
                    else ok = 0;
                end
                @(negedge clk);
            end
            chk(ok && seen == (exp_irq ? 8 : 0), "R10", seen, exp_irq ? 8 : 0);
        end
    endtask

    initial begin
        int t, ec, v, hold;
        bit mu;
        string tag, ctag;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0, "R1", int'(busy_o), 0);
        chk(done_o === 1'b0 && eot_irq_o === 1'b0, "R1", int'(done_o | eot_irq_o), 0);
        chk(int'(cnt_o) == 0, "R1", int'(cnt_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mcnt = 0;

        // R13: request at count zero is discarded, also after a later load
        set_cfg(1, 1, 0, 0, 0, 0, 0, 0);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(busy_o === 1'b0, "R13", int'(busy_o), 0);
            @(negedge clk);
        end
        load(3);
        for (int i = 0; i < 2; i++) begin
            chk(busy_o === 1'b0, "R13", int'(busy_o), 0);
            @(negedge clk);
        end

        // R4: example pair, 36 then 32 clocks, strobe after the second
        load(2);
        set_cfg(1, 1, 0, 0, 0, 0, 0, 0);
        launch(0);
        observe(36, 1, 0, 1, 0, "R4", "R9");
        mcnt = 1;
        launch(0);
        observe(32, 0, 1, 1, 0, "R4", "R10");
        mcnt = 0;

        // R5: calculation term with fixed and incrementing source
        load(3);
        set_cfg(0, 0, 1, 1, 0, 0, 0, 0);
        launch(0);
        observe(6 + 34 + 4, 2, 0, 1, 0, "R5", "R9");
        mcnt = 2;
        set_cfg(1, 1, 1, 1, 0, 0, 0, 0);
        launch(0);
        observe(6 + 33 + 4, 1, 0, 1, 0, "R5", "R9");
        mcnt = 1;

        // R6: chain term, n = 0 at count 1 so only the base applies
        set_cfg(0, 1, 1, 0, 1, 0, 0, 0);
        launch(0);
        observe(6 + 26, 0, 1, 1, 0, "R6", "R9");
        load(4);
        set_cfg(0, 1, 1, 0, 1, 0, 0, 0);
        launch(0);
        observe(6 + 26 + 8, 3, 0, 1, 0, "R6", "R9");
        mcnt = 3;

        // R8: multiple mode with k = 0 and k = 7
        set_cfg(1, 1, 1, 0, 0, 1, 1, 0);
        launch(0);
        observe(21, 2, 0, 1, 0, "R8", "R8");
        mcnt = 2;
        set_cfg(0, 0, 0, 1, 1, 0, 1, 7);
        launch(0);
        observe(21 + 13 * 7, 1, 0, 1, 0, "R8", "R8");
        mcnt = 1;

        // R7: burst at count 1, then burst at count 4 with inputs toggled (R14)
        set_cfg(0, 0, 0, 0, 0, 1, 0, 0);
        launch(0);
        observe(6 + 28, 0, 1, 1, 0, "R7", "R7");
        load(4);
        set_cfg(1, 1, 0, 1, 1, 1, 0, 0);
        launch(0);
        observe(6 + 34 * 4 + 8, 0, 1, 1, 1, "R14", "R7");
        mcnt = 0;

        // R12: request parked while busy, a second one discarded
        load(5);
        set_cfg(0, 0, 1, 0, 0, 0, 0, 0);
        t = exp_time();
        launch(0);
        set_cfg(1, 1, 0, 1, 1, 0, 0, 0);
        req_i = 1'b1;
        @(negedge clk);
        set_cfg(0, 0, 0, 0, 0, 1, 1, 7);
        @(negedge clk);
        req_i = 1'b0;
        scramble_cfg();
        observe(t - 2, 4, 0, 0, 0, "R4", "R9");
        mcnt = 4;
        set_cfg(1, 1, 0, 1, 1, 0, 0, 0);
        chk(busy_o === 1'b0, "R12", int'(busy_o), 0);
        @(negedge clk);
        chk(busy_o === 1'b1, "R12", int'(busy_o), 1);
        observe(exp_time(), 3, 0, 1, 0, "R12", "R9");
        mcnt = 3;
        chk(busy_o === 1'b0, "R12", int'(busy_o), 0);

        // random transfers, some held off by the priority input
        for (int it = 0; it < 40; it++) begin
            v = 1 + int'($urandom % 6);
            hold = ($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 0;
            mu = ($urandom % 4 == 0);
            load(v);
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), mu, int'($urandom % 8));
            t = exp_time();
            ec = exp_after();
            if (m_multi)      begin tag = "R8"; ctag = "R8"; end
            else if (m_burst) begin tag = "R7"; ctag = "R7"; end
            else if (m_calc)  begin tag = "R5"; ctag = "R9"; end
            else if (m_chain) begin tag = "R6"; ctag = "R9"; end
            else              begin tag = "R4"; ctag = "R9"; end
            launch(hold);
            observe(t, ec, ec == 0, 1, 1, tag, ctag);
            mcnt = ec;
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule